// File: doc/BRIEF.md
# Sampled-Clock Eye Centering Aligner

This block sets the sampling phase of a deserializer so that it sits in the middle of the valid region of a forwarded pixel clock. The deserializer samples that clock into a 7-bit word. When the sampling phase is inside the eye, the word always shows one fixed shape. The aligner moves an external phase shifter one step at a time. At each position it judges the position good or bad with a long run filter. It walks forward until it has left the region it started in, then searches forward for the leading edge of the next valid region. It measures how many positions stay good and finally steps backward half of that count.

One pulse on `start` runs one alignment. The block drives the shifter through a one-cycle request with a direction bit and waits for the shifter's completion pulse before it looks at any more samples. At the end it emits a one-cycle `done` with `ok` telling success from a failed search. The measured width stays on an output for debug.

Top module: `eyeCenterAligner`

## Requirements
- R1: A sample word counts as a match only when all seven bits equal 7'b1100011 (bit 6 first); a word that differs in any single bit is a mismatch.
- R2: A phase position is judged good only after FILTER_LEN consecutive valid-strobed samples all match. The first mismatching valid sample judges it bad and ends the evaluation. Each evaluation starts with a fresh count.
- R3: Leaving phase: while the current position is good, the block steps forward (shiftDir=1). At the first bad position it takes exactly one more forward step.
- R4: Seek phase: while the position is bad, the block steps forward and counts the steps. If the count exceeds MAX_STEPS, the block finishes with ok=0, so it issues exactly MAX_STEPS+1 seek steps. A search that needs exactly MAX_STEPS steps still succeeds.
- R5: Measure phase: at the first good position the width becomes 1 and the block steps forward. Each further good position adds one to the width and adds another forward step. On success, windowWidth equals the number of consecutive good positions. windowWidth is 0 from start until the measure phase begins and holds its value after done.
- R6: Back-off: after the first bad position in the measure phase, the block takes width/2 backward steps (shiftDir=0, integer division) and finishes with ok=1. No backward step is taken when width/2 is 0. Backward steps occur only in this phase.
- R7: Every step is a single-cycle shiftReq with a valid shiftDir. No new request is issued and no sample is consumed until shiftDone has been seen for that step.
- R8: done is a single-cycle pulse with ok valid alongside it. While idle, samples and shiftDone have no effect. A start while busy is ignored.
- R9: After reset, shiftReq, done and ok are 0 and windowWidth is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin one alignment run (idle only) |
| sampleValid | input | 1 | Strobe marking a new sampled-clock word |
| sampleWord | input | PAT_W | Sampled clock word from the deserializer |
| shiftDone | input | 1 | Phase shifter finished the requested step |
| shiftReq | output | 1 | One-cycle request for one phase step |
| shiftDir | output | 1 | Step direction, 1 forward, 0 backward |
| done | output | 1 | One-cycle end-of-run pulse |
| ok | output | 1 | Run result, 1 centered, 0 search exhausted |
| windowWidth | output | WIDTH_W | Measured width of the valid window |

## Verification
The hardest case to reach is a position that matches on all but one sample in each filter run: it must be judged bad even though almost every word is right. The bench models a ring of phase positions in which one edge position emits a mismatch on every FILTER_LEN-th valid strobe, so any full run of samples at that position contains exactly one flaw. The expected result is then the same as for an eye one position narrower. The bench also drives the opposite verdict's word during every pending step, which exposes any sample consumed before shiftDone. It places the start position so that the seek distance is exactly the bound and one past it.

// File: rtl/eyeAlignPkg.sv
package eyeAlignPkg;

  // Strobes from the sequencer to the datapath counters.
  typedef struct packed {
    logic evalEn;       // consume samples into the run filter
    logic clrRun;       // clear all per-run counters at start
    logic incSeek;      // one more step taken while searching
    logic setWidthOne;  // first good position of the window
    logic incWidth;     // one more good position in the window
    logic loadBack;     // load backward step count from width/2
    logic decBack;      // one backward step completed
  } alignStrobeT;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_EVAL,
    ST_REQ,
    ST_WAIT,
    ST_DONE
  } seqStateT;

  typedef enum logic [2:0] {
    PH_LEAVE,
    PH_EXTRA,
    PH_SEEK,
    PH_MEASURE,
    PH_BACK
  } seqPhaseT;

endpackage

// File: rtl/eyeAlignDatapath.sv
module eyeAlignDatapath
  import eyeAlignPkg::*;
#(
  parameter int PAT_W = 7,
  parameter logic [PAT_W-1:0] PATTERN = 7'b1100011,
  parameter int FILTER_LEN = 128,
  parameter int MAX_STEPS = 1024,
  parameter int WIDTH_W = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  alignStrobeT        strobe,
  input  logic               sampleValid,
  input  logic [PAT_W-1:0]   sampleWord,
  output logic               posGood,
  output logic               posBad,
  output logic               seekOver,
  output logic               halfZero,
  output logic               backLast,
  output logic [WIDTH_W-1:0] windowWidth
);

  localparam int FILT_W = (FILTER_LEN > 1) ? $clog2(FILTER_LEN) : 1;
  localparam logic [FILT_W-1:0] FILT_LAST = FILT_W'(FILTER_LEN - 1);
  localparam int SEEK_W = $clog2(MAX_STEPS + 2);
  localparam logic [SEEK_W-1:0] SEEK_LIMIT = SEEK_W'(MAX_STEPS);
  localparam logic [WIDTH_W-1:0] WIDTH_MAX = '1;

  // Bitwise comparison against the expected clock shape.
  logic [PAT_W-1:0] bitDiff;
  logic wordMatch;

  genvar gi;
  generate
    for (gi = 0; gi < PAT_W; gi++) begin : gBitCmp
      assign bitDiff[gi] = sampleWord[gi] ^ PATTERN[gi];
    end
  endgenerate

  assign wordMatch = ~|bitDiff;

  // Run filter: consecutive matching valid samples at the current position.
  logic [FILT_W-1:0] filtCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      filtCnt <= '0;
    end else if (strobe.clrRun || !strobe.evalEn) begin
      filtCnt <= '0;
    end else if (sampleValid) begin
      filtCnt <= wordMatch ? filtCnt + 1'b1 : '0;
    end
  end

  assign posGood = strobe.evalEn && sampleValid && wordMatch && (filtCnt == FILT_LAST);
  assign posBad  = strobe.evalEn && sampleValid && !wordMatch;

  // Forward steps taken while searching for the next window edge.
  logic [SEEK_W-1:0] seekCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seekCnt <= '0;
    end else if (strobe.clrRun) begin
      seekCnt <= '0;
    end else if (strobe.incSeek) begin
      seekCnt <= seekCnt + 1'b1;
    end
  end

  assign seekOver = seekCnt > SEEK_LIMIT;

  // Window width, saturating.
  logic [WIDTH_W-1:0] widthReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      widthReg <= '0;
    end else if (strobe.clrRun) begin
      widthReg <= '0;
    end else if (strobe.setWidthOne) begin
      widthReg <= WIDTH_W'(1);
    end else if (strobe.incWidth && (widthReg != WIDTH_MAX)) begin
      widthReg <= widthReg + 1'b1;
    end
  end

  assign windowWidth = widthReg;
  assign halfZero = (widthReg >> 1) == '0;

  // Remaining backward steps toward the window centre.
  logic [WIDTH_W-1:0] backCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      backCnt <= '0;
    end else if (strobe.clrRun) begin
      backCnt <= '0;
    end else if (strobe.loadBack) begin
      backCnt <= widthReg >> 1;
    end else if (strobe.decBack) begin
      backCnt <= backCnt - 1'b1;
    end
  end

  assign backLast = backCnt == WIDTH_W'(1);

  assert_filter_range_R2: assert property (@(posedge clk) disable iff (!rstN)
    filtCnt <= FILT_LAST);

  assert_fresh_window_R2: assert property (@(posedge clk) disable iff (!rstN)
    (posGood || posBad) |=> (filtCnt == '0));

  assert_seek_bound_R4: assert property (@(posedge clk) disable iff (!rstN)
    seekCnt <= SEEK_W'(MAX_STEPS + 1));

  assert_back_underflow_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.decBack |-> (backCnt != '0));

endmodule

// File: rtl/eyeAlignCtrl.sv
module eyeAlignCtrl
  import eyeAlignPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        shiftDone,
  input  logic        posGood,
  input  logic        posBad,
  input  logic        seekOver,
  input  logic        halfZero,
  input  logic        backLast,
  output alignStrobeT strobe,
  output logic        shiftReq,
  output logic        shiftDir,
  output logic        done,
  output logic        ok
);

  seqStateT state, stateNext;
  seqPhaseT phase, phaseNext;
  logic dirReg, dirNext;
  logic okReg, okNext;

  always_comb begin
    stateNext = state;
    phaseNext = phase;
    dirNext   = dirReg;
    okNext    = okReg;
    strobe    = '0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          strobe.clrRun = 1'b1;
          phaseNext = PH_LEAVE;
          okNext = 1'b0;
          stateNext = ST_EVAL;
        end
      end
      ST_EVAL: begin
        strobe.evalEn = 1'b1;
        if (posGood) begin
          dirNext = 1'b1;
          stateNext = ST_REQ;
          if (phase == PH_SEEK) begin
            strobe.setWidthOne = 1'b1;
            phaseNext = PH_MEASURE;
          end else if (phase == PH_MEASURE) begin
            strobe.incWidth = 1'b1;
          end
        end else if (posBad) begin
          unique case (phase)
            PH_LEAVE: begin
              phaseNext = PH_EXTRA;
              dirNext = 1'b1;
              stateNext = ST_REQ;
            end
            PH_SEEK: begin
              strobe.incSeek = 1'b1;
              dirNext = 1'b1;
              stateNext = ST_REQ;
            end
            default: begin
              if (halfZero) begin
                okNext = 1'b1;
                stateNext = ST_DONE;
              end else begin
                strobe.loadBack = 1'b1;
                phaseNext = PH_BACK;
                dirNext = 1'b0;
                stateNext = ST_REQ;
              end
            end
          endcase
        end
      end
      ST_REQ: stateNext = ST_WAIT;
      ST_WAIT: begin
        if (shiftDone) begin
          unique case (phase)
            PH_EXTRA: begin
              phaseNext = PH_SEEK;
              stateNext = ST_EVAL;
            end
            PH_SEEK: begin
              if (seekOver) begin
                okNext = 1'b0;
                stateNext = ST_DONE;
              end else begin
                stateNext = ST_EVAL;
              end
            end
            PH_BACK: begin
              strobe.decBack = 1'b1;
              if (backLast) begin
                okNext = 1'b1;
                stateNext = ST_DONE;
              end else begin
                stateNext = ST_REQ;
              end
            end
            default: stateNext = ST_EVAL;
          endcase
        end
      end
      ST_DONE: stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      phase  <= PH_LEAVE;
      dirReg <= 1'b1;
      okReg  <= 1'b0;
    end else begin
      state  <= stateNext;
      phase  <= phaseNext;
      dirReg <= dirNext;
      okReg  <= okNext;
    end
  end

  assign shiftReq = state == ST_REQ;
  assign shiftDir = dirReg;
  assign done     = state == ST_DONE;
  assign ok       = okReg;

  assert_req_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    shiftReq |=> !shiftReq);

  assert_wait_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT && !shiftDone) |=> (state == ST_WAIT));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_ok_rise_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ok) |-> done);

  assert_back_dir_R6: assert property (@(posedge clk) disable iff (!rstN)
    (shiftReq && !shiftDir) |-> (phase == PH_BACK));

endmodule

// File: rtl/eyeCenterAligner.sv
module eyeCenterAligner
  import eyeAlignPkg::*;
#(
  parameter int PAT_W = 7,
  parameter logic [PAT_W-1:0] PATTERN = 7'b1100011,
  parameter int FILTER_LEN = 128,
  parameter int MAX_STEPS = 1024,
  parameter int WIDTH_W = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic               sampleValid,
  input  logic [PAT_W-1:0]   sampleWord,
  input  logic               shiftDone,
  output logic               shiftReq,
  output logic               shiftDir,
  output logic               done,
  output logic               ok,
  output logic [WIDTH_W-1:0] windowWidth
);

  alignStrobeT strobe;
  logic posGood, posBad, seekOver, halfZero, backLast;

  eyeAlignCtrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .shiftDone(shiftDone),
    .posGood  (posGood),
    .posBad   (posBad),
    .seekOver (seekOver),
    .halfZero (halfZero),
    .backLast (backLast),
    .strobe   (strobe),
    .shiftReq (shiftReq),
    .shiftDir (shiftDir),
    .done     (done),
    .ok       (ok)
  );

  eyeAlignDatapath #(
    .PAT_W     (PAT_W),
    .PATTERN   (PATTERN),
    .FILTER_LEN(FILTER_LEN),
    .MAX_STEPS (MAX_STEPS),
    .WIDTH_W   (WIDTH_W)
  ) uData (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .sampleValid(sampleValid),
    .sampleWord (sampleWord),
    .posGood    (posGood),
    .posBad     (posBad),
    .seekOver   (seekOver),
    .halfZero   (halfZero),
    .backLast   (backLast),
    .windowWidth(windowWidth)
  );

endmodule

// File: tb/sim_eyeCenterAligner.sv
`timescale 1ns/1ps
module sim_eyeCenterAligner;
  localparam int FILT = 8;
  localparam int MAXS = 20;
  localparam int WW = 8;
  localparam logic [6:0] PAT = 7'b1100011;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic sampleValid = 1'b0;
  logic shiftDone = 1'b0;
  logic [6:0] sampleWord = '0;
  logic shiftReq, shiftDir, done, ok;
  logic [WW-1:0] windowWidth;

  always #2 clk = ~clk;

  eyeCenterAligner #(
    .PAT_W(7), .PATTERN(PAT), .FILTER_LEN(FILT), .MAX_STEPS(MAXS), .WIDTH_W(WW)
  ) u0 (
    .clk(clk), .rstN(rstN), .start(start), .sampleValid(sampleValid),
    .sampleWord(sampleWord), .shiftDone(shiftDone), .shiftReq(shiftReq),
    .shiftDir(shiftDir), .done(done), .ok(ok), .windowWidth(windowWidth)
  );

  int total = 0, bad = 0, cyc = 0;
  // scenario, written by the main sequence
  int ring = 12, eyeLo = 3, eyeLen = 4, glitchPos = -1, startPos = 0, loadSeq = 0;
  logic idlePoke = 1'b0;
  // environment state, written by the shifter model
  int pos = 0, fwdCnt = 0, backCnt = 0, overlap = 0, pendCnt = 0, stepNo = 0;
  int seenSeq = 0, gCount = 0;
  bit pendDir = 1'b1;

  function automatic bit isGood(int p);
    int off;
    if (eyeLen <= 0) return 1'b0;
    off = ((p - eyeLo) % ring + ring) % ring;
    return off < eyeLen;
  endfunction

  // Phase shifter and deserializer model.
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (seenSeq != loadSeq) begin
        seenSeq = loadSeq; pos = startPos; fwdCnt = 0; backCnt = 0; overlap = 0; pendCnt = 0;
      end
      shiftDone = idlePoke;
      if (pendCnt > 0) begin
        pendCnt--;
        if (pendCnt == 0) begin
          shiftDone = 1'b1;
          pos = pendDir ? (pos + 1) % ring : (pos + ring - 1) % ring;
        end
      end
      if (shiftReq === 1'b1) begin
        if (pendCnt > 0) overlap++;
        pendCnt = 1 + (stepNo % 4);
        stepNo++;
        pendDir = shiftDir;
        if (shiftDir) fwdCnt++; else backCnt++;
      end
      sampleValid = (cyc % 3) != 0;
      if (pendCnt > 0)
        sampleWord = isGood(pos) ? (PAT ^ 7'h01) : PAT;  // opposite verdict while stepping
      else if (isGood(pos) && !(pos == glitchPos && (gCount % FILT) == 0))
        sampleWord = PAT;
      else
        sampleWord = PAT ^ (7'h01 << (cyc % 7));          // single-bit miss
      if (sampleValid) gCount++;
    end
  end

  task automatic check(bit cond, string tag, int act, int exp);
    total++;
    if (!cond) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic runCase(int r, int lo, int len, int gl, int p0, int mLo, int mLen, bit busyStart);
    int off, leave, e1, k, expFwd, expBack, expWidth, expFinal, n;
    bit sGood, expOk;
    off = ((p0 - mLo) % r + r) % r;
    sGood = (mLen > 0) && (off < mLen);
    leave = sGood ? (mLen - off) : 0;
    e1 = sGood ? (mLo + mLen + 1) % r : (p0 + 1) % r;
    k = ((mLo - e1) % r + r) % r;
    if (mLen == 0 || k > MAXS) begin
      expOk = 1'b0; expFwd = leave + 1 + MAXS + 1; expBack = 0; expWidth = 0;
      expFinal = (p0 + expFwd) % r;
    end else begin
      expOk = 1'b1; expFwd = leave + 1 + k + mLen; expBack = mLen / 2; expWidth = mLen;
      expFinal = (mLo + mLen - mLen / 2) % r;
    end
    ring = r; eyeLo = lo; eyeLen = len; glitchPos = gl; startPos = p0; loadSeq++;
    repeat (2) @(negedge clk);
    start = 1'b1; @(negedge clk); start = 1'b0;
    if (busyStart) begin
      repeat (3) @(negedge clk);
      start = 1'b1; @(negedge clk); start = 1'b0;
    end
    n = 0;
    while (done !== 1'b1 && n < 20000) begin @(negedge clk); n++; end
    check(done === 1'b1, "R8 done reached", int'(done), 1);
    check(ok === expOk, "R4 R6 result flag", int'(ok), int'(expOk));
    check(int'(windowWidth) == expWidth, "R5 window width", int'(windowWidth), expWidth);
    check(fwdCnt == expFwd, "R3 R4 forward steps", fwdCnt, expFwd);
    check(backCnt == expBack, "R6 backward steps", backCnt, expBack);
    check(pos == expFinal, "R6 final phase", pos, expFinal);
    check(overlap == 0, "R7 request before done", overlap, 0);
    @(negedge clk);
    check(done === 1'b0, "R8 done one cycle", int'(done), 0);
    check(int'(windowWidth) == expWidth, "R5 width held", int'(windowWidth), expWidth);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(shiftReq === 1'b0, "R9 reset req", int'(shiftReq), 0);
    check(done === 1'b0, "R9 reset done", int'(done), 0);
    check(ok === 1'b0, "R9 reset ok", int'(ok), 0);
    check(windowWidth === '0, "R9 reset width", int'(windowWidth), 0);
    rstN = 1'b1;
    // R8: idle ignores shiftDone and samples
    idlePoke = 1'b1;
    repeat (12) @(negedge clk);
    idlePoke = 1'b0;
    @(negedge clk);
    check(fwdCnt + backCnt == 0, "R8 idle no step", fwdCnt + backCnt, 0);
    check(done === 1'b0, "R8 idle no done", int'(done), 0);
    // R1 R2 R3 R5 R6: sweep of window widths and start phases
    for (int len = 1; len <= 10; len++)
      for (int p0 = 0; p0 < 12; p0++)
        runCase(12, 3, len, -1, p0, 3, len, p0 == 5);
    // R2: leading edge position misses once in every filter run
    runCase(12, 3, 5, 3, 0, 4, 4, 1'b0);
    runCase(12, 3, 5, 3, 3, 4, 4, 1'b0);
    runCase(12, 3, 5, 3, 6, 4, 4, 1'b0);
    // R4: seek distance exactly at and one past the bound
    runCase(24, 0, 2, -1, 3, 0, 2, 1'b0);
    runCase(24, 0, 2, -1, 2, 0, 2, 1'b0);
    // R4: no valid window at all
    runCase(12, 0, 0, -1, 0, 0, 0, 1'b0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule